// File: doc/BRIEF.md
# Weighted motion compensation accumulator

This block builds one expanded block of an interpolated frame by overlapped, weighted motion compensation. Every accepted sample carries the 2x2 neighbourhood around the motion-compensated position in the previous frame and in the current frame, a quarter-pixel fraction for each, and an occlusion flag. Two bilinear units turn these into one prediction per frame. The prediction that goes on is either the current-frame value alone, where the sample is occluded, or the rounded average of both. The difference between the two predictions is also kept. A weight taken from a tent-shaped matrix the size of the expanded block scales the prediction and the difference. The weighted prediction, the weighted difference and the weight are added into a per-position accumulation buffer.

Samples arrive one per cycle in raster order over a square pass of 12x12 positions (4x4 blocks) or 16x16 positions (8x8 blocks). Several passes may overlap in the buffer. A normalization request drains the buffer in raster order. Each position's sums are scaled by a reciprocal of its weight total, read from a table, and each position is emptied as it leaves. A position with no accumulated weight leaves as a hole. Both the sample input and the drained output are valid/ready streams. A sample moves only when `in_valid` and `in_ready` are both high. A drained word stays on the output until `out_ready` takes it. While `out_valid` is high and `out_ready` is low, the word does not change.

Top module: `wmc_accum`

## Requirements
- R1: Each bilinear value is ((4-fx)(4-fy)A + fx(4-fy)B + (4-fx)fy C + fx fy D + 8) >> 4. A, B, C and D are the top-left, top-right, bottom-left and bottom-right neighbours, at bits [7:0], [15:8], [23:16] and [31:24] of the neighbour bus. fx and fy are in quarter pixels.
- R2: With `occluded`=1 the prediction is the current-frame bilinear value. Otherwise it is (prev + cur + 1) >> 1.
- R3: The difference is cur - prev of the two bilinear values, as a signed number. It is multiplied by the weight and added to a per-position signed sum.
- R4: `blk_mode`=0 selects a 12x12 pass and 1 selects a 16x16 pass. Positions are visited row-major from (0,0). The weight at row r, column c is min(4*t(r)*t(c), 255), where t(k) = min(k+1, N-k) and N is the pass side.
- R5: Prediction*weight, difference*weight and weight are each added to the sums held for that position. Up to 4 passes accumulate. `blk_mode` is sampled with the first sample of each pass and holds for the rest of that pass.
- R6: With S the sum and W the weight total, R(W) = (65536 + W/2) / W in integer arithmetic. The drained pixel is (S*R + 32768) >> 16, saturated to 255. The drained difference is (S*R + 32768) >>> 16 taken as a floor, saturated to -256..255.
- R7: A position with weight total 0 drains with `out_hole`=1, pixel 0 and difference 0.
- R8: A drain covers the N x N positions of the side selected by `blk_mode` when the drain starts, in row-major order. `out_last` marks the final word. Each drained position is cleared. `out_valid` falls after the last word is taken.
- R9: A `norm_start` pulse during a pass is held until the pass ends. If the pulse coincides with the last sample of a pass, that sample is included and the drain is valid in the next cycle.
- R10: `in_ready` is low for the whole of a drain. `norm_start` and `in_valid` during a drain have no effect.
- R11: While `out_valid` is high and `out_ready` is low, the output word holds steady.
- R12: After reset `in_ready` is 1, `out_valid` is 0, and every position is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_mode | input | 1 | 0: 12x12 side, 1: 16x16 side |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample accepted when high with in_valid |
| prev_nb | input | 32 | Previous-frame 2x2 neighbours |
| cur_nb | input | 32 | Current-frame 2x2 neighbours |
| prev_fx | input | 2 | Previous-frame horizontal fraction |
| prev_fy | input | 2 | Previous-frame vertical fraction |
| cur_fx | input | 2 | Current-frame horizontal fraction |
| cur_fy | input | 2 | Current-frame vertical fraction |
| occluded | input | 1 | Sample lies in an occluded area |
| norm_start | input | 1 | Request a normalization drain |
| out_valid | output | 1 | Drained word present |
| out_ready | input | 1 | Consumer takes the word |
| out_pix | output | 8 | Normalized pixel |
| out_diff | output | 9 | Normalized signed difference |
| out_hole | output | 1 | Position had no weight |
| out_last | output | 1 | Final word of the drain |

## Verification
Two functions can fall in one cycle: the last sample of a pass is written into the buffer, and a drain request arrives. The bench raises `norm_start` together with that last sample. It then requires the drain to be valid on the following cycle, and the drained value at the final position to include that sample's contribution. A second case raises the request in the middle of a pass and requires the pass to finish undisturbed before the drain begins. A third pokes both `in_valid` and `norm_start` during a drain. A later empty drain must then show that neither had any effect.

// File: rtl/wmc_pkg.sv
package wmc_pkg;
  // Tent tap along one axis of a side-long expanded block; 0 outside it.
  function automatic int tri_tap(input int k, input int side);
    if (k >= side) return 0;
    return (k + 1 < side - k) ? k + 1 : side - k;
  endfunction
endpackage

// File: rtl/wmc_bilin.sv
module wmc_bilin #(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 2
) (
  input  logic [4*PIX_W-1:0] nb,
  input  logic [FRAC_W-1:0]  fx,
  input  logic [FRAC_W-1:0]  fy,
  output logic [PIX_W-1:0]   y
);
  localparam int CW = FRAC_W + 1;
  localparam int SW = PIX_W + 2 * CW;
  localparam logic [CW-1:0] ONE = CW'(1) << FRAC_W;
  localparam logic [SW-1:0] RND = SW'(1) << (2 * FRAC_W - 1);

  logic [CW-1:0] hx0, hx1, vy0, vy1;
  logic [SW-1:0] acc;

  always_comb begin
    hx1 = {1'b0, fx};
    hx0 = ONE - hx1;
    vy1 = {1'b0, fy};
    vy0 = ONE - vy1;
    acc = SW'(hx0) * SW'(vy0) * SW'(nb[0*PIX_W +: PIX_W])
        + SW'(hx1) * SW'(vy0) * SW'(nb[1*PIX_W +: PIX_W])
        + SW'(hx0) * SW'(vy1) * SW'(nb[2*PIX_W +: PIX_W])
        + SW'(hx1) * SW'(vy1) * SW'(nb[3*PIX_W +: PIX_W])
        + RND;
    y = PIX_W'(acc >> (2 * FRAC_W));
  end
endmodule

// File: rtl/wmc_weight.sv
module wmc_weight #(
  parameter int SIDE_W    = 4,
  parameter int EXP_MAX   = 16,
  parameter int EXP_SMALL = 12,
  parameter int WGT_W     = 8,
  parameter int WGT_SHIFT = 2
) (
  input  logic              big_mode,
  input  logic [SIDE_W-1:0] row,
  input  logic [SIDE_W-1:0] col,
  output logic [WGT_W-1:0]  wgt
);
  localparam int PW = 2 * SIDE_W + WGT_SHIFT;
  localparam int NT = 1 << SIDE_W;
  localparam logic [PW-1:0] WMAX = PW'((1 << WGT_W) - 1);

  logic [SIDE_W-1:0] tap_big   [NT];
  logic [SIDE_W-1:0] tap_small [NT];

  for (genvar k = 0; k < NT; k++) begin : g_tap
    assign tap_big[k]   = SIDE_W'(wmc_pkg::tri_tap(k, EXP_MAX));
    assign tap_small[k] = SIDE_W'(wmc_pkg::tri_tap(k, EXP_SMALL));
  end

  logic [SIDE_W-1:0] ta, tb;
  logic [PW-1:0]     prod;

  always_comb begin
    ta   = big_mode ? tap_big[row] : tap_small[row];
    tb   = big_mode ? tap_big[col] : tap_small[col];
    prod = (PW'(ta) * PW'(tb)) << WGT_SHIFT;
    wgt  = (prod > WMAX) ? WMAX[WGT_W-1:0] : prod[WGT_W-1:0];
  end
endmodule

// File: rtl/wmc_norm.sv
module wmc_norm #(
  parameter int PIX_W    = 8,
  parameter int PSUM_W   = 18,
  parameter int DSUM_W   = 19,
  parameter int WSUM_W   = 10,
  parameter int RECIP_FB = 16
) (
  input  logic [PSUM_W-1:0]        psum,
  input  logic signed [DSUM_W-1:0] dsum,
  input  logic [WSUM_W-1:0]        wsum,
  output logic [PIX_W-1:0]         pix,
  output logic signed [PIX_W:0]    diff,
  output logic                     hole
);
  localparam int RECIP_W = RECIP_FB + 1;
  localparam int ROM_N   = 1 << WSUM_W;
  localparam int PM_W    = PSUM_W + RECIP_W;
  localparam int DM_W    = DSUM_W + RECIP_W + 1;
  localparam logic [PM_W-1:0] PRND = PM_W'(1) << (RECIP_FB - 1);
  localparam logic signed [DM_W-1:0] DRND = DM_W'(1) << (RECIP_FB - 1);

  logic [RECIP_W-1:0] rom [ROM_N];
  for (genvar i = 0; i < ROM_N; i++) begin : g_rom
    localparam longint unsigned DEN = (i == 0) ? 1 : i;
    localparam longint unsigned VAL = (i == 0) ? 0 : (((64'd1 << RECIP_FB) + DEN / 2) / DEN);
    assign rom[i] = RECIP_W'(VAL);
  end

  logic [RECIP_W-1:0]     recip;
  logic [PM_W-1:0]        pm, pq;
  logic signed [DM_W-1:0] dm, dq;
  logic                   p_fit, d_fit;

  always_comb begin
    recip = rom[wsum];
    pm    = PM_W'(psum) * PM_W'(recip);
    pq    = (pm + PRND) >> RECIP_FB;
    dm    = DM_W'(dsum) * $signed(DM_W'({1'b0, recip}));
    dq    = (dm + DRND) >>> RECIP_FB;
    p_fit = (pq >> PIX_W) == '0;
    d_fit = (dq[DM_W-1:PIX_W] == '0) || (dq[DM_W-1:PIX_W] == '1);
    hole  = (wsum == '0);
    if (hole) begin
      pix  = '0;
      diff = '0;
    end else begin
      pix  = p_fit ? pq[PIX_W-1:0] : '1;
      diff = d_fit ? dq[PIX_W:0] : (dq[DM_W-1] ? {1'b1, {PIX_W{1'b0}}} : {1'b0, {PIX_W{1'b1}}});
    end
  end
endmodule

// File: rtl/wmc_accum.sv
module wmc_accum #(
  parameter int PIX_W     = 8,
  parameter int FRAC_W    = 2,
  parameter int WGT_W     = 8,
  parameter int WGT_SHIFT = 2,
  parameter int PASS_LOG2 = 2,
  parameter int EXP_MAX   = 16,
  parameter int EXP_SMALL = 12,
  parameter int RECIP_FB  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   blk_mode,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [4*PIX_W-1:0]     prev_nb,
  input  logic [4*PIX_W-1:0]     cur_nb,
  input  logic [FRAC_W-1:0]      prev_fx,
  input  logic [FRAC_W-1:0]      prev_fy,
  input  logic [FRAC_W-1:0]      cur_fx,
  input  logic [FRAC_W-1:0]      cur_fy,
  input  logic                   occluded,
  input  logic                   norm_start,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [PIX_W-1:0]       out_pix,
  output logic signed [PIX_W:0]  out_diff,
  output logic                   out_hole,
  output logic                   out_last
);
  localparam int SIDE_W = $clog2(EXP_MAX);
  localparam int ADDR_W = 2 * SIDE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WSUM_W = WGT_W + PASS_LOG2;
  localparam int PSUM_W = PIX_W + WGT_W + PASS_LOG2;
  localparam int DSUM_W = PIX_W + 1 + WGT_W + PASS_LOG2;
  localparam logic [SIDE_W-1:0] MAX_LAST   = SIDE_W'(EXP_MAX - 1);
  localparam logic [SIDE_W-1:0] SMALL_LAST = SIDE_W'(EXP_SMALL - 1);

  // Accumulation storage, one entry per position of the largest pass.
  logic [PSUM_W-1:0]        psum_q [DEPTH];
  logic signed [DSUM_W-1:0] dsum_q [DEPTH];
  logic [WSUM_W-1:0]        wsum_q [DEPTH];

  // Pass and drain sequencing state.
  logic [SIDE_W-1:0] acc_r, acc_c, drn_r, drn_c;
  logic              pass_mode, drn_mode, norm_pend, draining;

  // Prediction path.
  logic [PIX_W-1:0]        p_bil, c_bil, pred;
  logic signed [PIX_W:0]   mcd;
  logic [WGT_W-1:0]        wgt;
  logic                    mode_now, pos_idle, acc_fire, pass_end, start_drain, drn_fire;
  logic [SIDE_W-1:0]       acc_last, drn_last;
  logic [ADDR_W-1:0]       acc_addr, drn_addr;
  logic [PSUM_W-1:0]       pprod;
  logic signed [DSUM_W-1:0] dprod;

  wmc_bilin #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_bil_prev (
    .nb(prev_nb), .fx(prev_fx), .fy(prev_fy), .y(p_bil));
  wmc_bilin #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_bil_cur (
    .nb(cur_nb), .fx(cur_fx), .fy(cur_fy), .y(c_bil));

  wmc_weight #(.SIDE_W(SIDE_W), .EXP_MAX(EXP_MAX), .EXP_SMALL(EXP_SMALL),
               .WGT_W(WGT_W), .WGT_SHIFT(WGT_SHIFT)) u_wgt (
    .big_mode(mode_now), .row(acc_r), .col(acc_c), .wgt(wgt));

  always_comb begin
    pos_idle = (acc_r == '0) && (acc_c == '0);
    mode_now = pos_idle ? blk_mode : pass_mode;
    acc_last = mode_now ? MAX_LAST : SMALL_LAST;
    drn_last = drn_mode ? MAX_LAST : SMALL_LAST;
    in_ready = !draining;
    acc_fire = in_valid && in_ready;
    pass_end = acc_fire && (acc_r == acc_last) && (acc_c == acc_last);
    start_drain = !draining && (norm_start || norm_pend) && (pass_end || (pos_idle && !acc_fire));
    drn_fire = draining && out_ready;
    acc_addr = {acc_r, acc_c};
    drn_addr = {drn_r, drn_c};
    pred  = occluded ? c_bil : PIX_W'(({1'b0, p_bil} + {1'b0, c_bil} + (PIX_W+1)'(1)) >> 1);
    mcd   = $signed({1'b0, c_bil}) - $signed({1'b0, p_bil});
    pprod = PSUM_W'(pred) * PSUM_W'(wgt);
    dprod = DSUM_W'(mcd) * $signed(DSUM_W'({1'b0, wgt}));
  end

  // Sequencing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_r <= '0; acc_c <= '0; pass_mode <= 1'b0;
      drn_r <= '0; drn_c <= '0; drn_mode <= 1'b0;
      norm_pend <= 1'b0; draining <= 1'b0;
    end else begin
      if (acc_fire) begin
        if (pos_idle) pass_mode <= blk_mode;
        if (acc_c == acc_last) begin
          acc_c <= '0;
          acc_r <= (acc_r == acc_last) ? '0 : acc_r + 1'b1;
        end else begin
          acc_c <= acc_c + 1'b1;
        end
      end
      if (start_drain) begin
        norm_pend <= 1'b0;
        draining  <= 1'b1;
        drn_mode  <= blk_mode;
        drn_r     <= '0;
        drn_c     <= '0;
      end else begin
        if (norm_start && !draining) norm_pend <= 1'b1;
        if (drn_fire) begin
          if (drn_c == drn_last) begin
            drn_c <= '0;
            if (drn_r == drn_last) begin
              drn_r    <= '0;
              draining <= 1'b0;
            end else begin
              drn_r <= drn_r + 1'b1;
            end
          end else begin
            drn_c <= drn_c + 1'b1;
          end
        end
      end
    end
  end

  // Buffer: read-modify-write on accept, clear on drain (never both).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        psum_q[i] <= '0;
        dsum_q[i] <= '0;
        wsum_q[i] <= '0;
      end
    end else if (acc_fire) begin
      psum_q[acc_addr] <= psum_q[acc_addr] + pprod;
      dsum_q[acc_addr] <= dsum_q[acc_addr] + dprod;
      wsum_q[acc_addr] <= wsum_q[acc_addr] + WSUM_W'(wgt);
    end else if (drn_fire) begin
      psum_q[drn_addr] <= '0;
      dsum_q[drn_addr] <= '0;
      wsum_q[drn_addr] <= '0;
    end
  end

  wmc_norm #(.PIX_W(PIX_W), .PSUM_W(PSUM_W), .DSUM_W(DSUM_W),
             .WSUM_W(WSUM_W), .RECIP_FB(RECIP_FB)) u_norm (
    .psum(psum_q[drn_addr]), .dsum(dsum_q[drn_addr]), .wsum(wsum_q[drn_addr]),
    .pix(out_pix), .diff(out_diff), .hole(out_hole));

  assign out_valid = draining;
  assign out_last  = draining && (drn_r == drn_last) && (drn_c == drn_last);
endmodule

// File: rtl/wmc_accum_chk.sv
module wmc_accum_chk #(
  parameter int PIX_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [PIX_W-1:0]      out_pix,
  input logic signed [PIX_W:0] out_diff,
  input logic                  out_hole,
  input logic                  out_last
);
  // R10
  drain_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R11
  stall_holds_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_diff)
                                && $stable(out_hole) && $stable(out_last));

  // R7
  hole_is_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hole |-> (out_pix == '0) && (out_diff == '0));

  // R8
  last_ends_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid && in_ready);

  // R12
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> in_ready && !out_valid);
endmodule

bind wmc_accum wmc_accum_chk #(.PIX_W(PIX_W)) u_wmc_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_pix(out_pix), .out_diff(out_diff),
  .out_hole(out_hole), .out_last(out_last));

// File: tb/wmc_accum_bench.sv
`timescale 1ns/1ps
module wmc_accum_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic blk_mode = 1'b0, in_valid = 1'b0, in_ready, occluded = 1'b0, norm_start = 1'b0;
  logic [31:0] prev_nb = '0, cur_nb = '0;
  logic [1:0]  prev_fx = '0, prev_fy = '0, cur_fx = '0, cur_fy = '0;
  logic out_valid, out_ready = 1'b0, out_hole, out_last;
  logic [7:0] out_pix;
  logic signed [8:0] out_diff;

  int n_vec = 0, n_bad = 0;
  longint mp [256], md [256], mw [256];

  always #4 clk = ~clk;

  wmc_accum u_wmc_accum (
    .clk(clk), .rst_n(rst_n), .blk_mode(blk_mode), .in_valid(in_valid), .in_ready(in_ready),
    .prev_nb(prev_nb), .cur_nb(cur_nb), .prev_fx(prev_fx), .prev_fy(prev_fy),
    .cur_fx(cur_fx), .cur_fy(cur_fy), .occluded(occluded), .norm_start(norm_start),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix), .out_diff(out_diff),
    .out_hole(out_hole), .out_last(out_last));

  function automatic longint bil(input logic [31:0] nb, input int fx, input int fy);
    return ((4-fx)*(4-fy)*nb[7:0] + fx*(4-fy)*nb[15:8] + (4-fx)*fy*nb[23:16]
            + fx*fy*nb[31:24] + 8) >> 4;
  endfunction

  function automatic longint tap(input int k, input int n);
    return (k + 1 < n - k) ? k + 1 : n - k;
  endfunction

  function automatic longint wgt(input bit mode, input int r, input int c);
    int n = mode ? 16 : 12;
    longint w = 4 * tap(r, n) * tap(c, n);
    return (w > 255) ? 255 : w;
  endfunction

  task automatic check1(input string tag, input bit ok, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_pass(input bit mode, input bit occ_pat, input bit gaps, input int norm_at);
    int n = mode ? 16 : 12;
    for (int k = 0; k < n * n; k++) begin
      int r = k / n, c = k % n;
      longint p, q, pr, d, w;
      @(negedge clk);
      if (gaps && (k % 5 == 2)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      blk_mode = mode;
      in_valid = 1'b1;
      prev_nb  = $urandom; cur_nb = $urandom;
      prev_fx  = 2'($urandom_range(0, 3)); prev_fy = 2'($urandom_range(0, 3));
      cur_fx   = 2'($urandom_range(0, 3)); cur_fy  = 2'($urandom_range(0, 3));
      occluded = occ_pat && ((r + c) % 3 == 0);
      norm_start = (k == norm_at);
      if (!in_ready) check1("R9 in_ready during pass", 1'b0, 0, 1);
      p  = bil(prev_nb, prev_fx, prev_fy);
      q  = bil(cur_nb, cur_fx, cur_fy);
      pr = occluded ? q : (p + q + 1) >> 1;
      d  = q - p;
      w  = wgt(mode, r, c);
      mp[r*16+c] += pr * w;
      md[r*16+c] += d * w;
      mw[r*16+c] += w;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    norm_start = 1'b0;
  endtask

  task automatic drain(input string tag, input bit mode, input bit pulse, input bit bp, input bit poke);
    int n = mode ? 16 : 12;
    int idx = 0, guard = 0;
    if (pulse) begin
      @(negedge clk);
      blk_mode = mode; norm_start = 1'b1;
      @(negedge clk);
      norm_start = 1'b0;
    end else begin
      check1({tag, " R9 drain valid next cycle"}, out_valid === 1'b1, out_valid, 1);
    end
    while (idx < n * n && guard < 5000) begin
      bit ok;
      int r = idx / n, c = idx % n;
      longint rc, ep, ed, eh, el;
      if (guard > 0) @(negedge clk);
      guard++;
      out_ready = bp ? ((guard % 3) != 1) : 1'b1;
      if (poke && idx == 5) begin
        in_valid = 1'b1; norm_start = 1'b1;
        check1("R10 in_ready low in drain", in_ready === 1'b0, in_ready, 0);
      end else if (poke) begin
        in_valid = 1'b0; norm_start = 1'b0;
      end
      if (out_valid && out_ready) begin
        eh = (mw[r*16+c] == 0);
        if (eh != 0) begin
          ep = 0; ed = 0;
        end else begin
          rc = (65536 + mw[r*16+c] / 2) / mw[r*16+c];
          ep = (mp[r*16+c] * rc + 32768) >>> 16;
          if (ep > 255) ep = 255;
          ed = (md[r*16+c] * rc + 32768) >>> 16;
          if (ed > 255) ed = 255;
          if (ed < -256) ed = -256;
        end
        el = (idx == n * n - 1);
        ok = (out_pix == ep) && (out_diff == ed) && (out_hole == eh) && (out_last == el);
        n_vec++;
        if (!ok) begin
          n_bad++;
          $display("FAIL %s pos=%0d pix=%0d/%0d diff=%0d/%0d hole=%0d/%0d last=%0d/%0d",
                   tag, idx, out_pix, ep, out_diff, ed, out_hole, eh, out_last, el);
        end
        mp[r*16+c] = 0; md[r*16+c] = 0; mw[r*16+c] = 0;
        idx++;
      end
    end
    if (idx < n * n) check1({tag, " R8 drain incomplete"}, 1'b0, idx, n * n);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b0; norm_start = 1'b0;
    check1({tag, " R8 out_valid after last"}, out_valid === 1'b0, out_valid, 0);
    repeat (3) @(negedge clk);
    check1({tag, " R10 stays idle"}, out_valid === 1'b0 && in_ready === 1'b1, out_valid, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check1("R12 in_ready", in_ready === 1'b1, in_ready, 1);
    check1("R12 out_valid", out_valid === 1'b0, out_valid, 0);
    rst_n = 1'b1;
    drain("R12/R7 empty drain", 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_single_big();   // R1 R2 R3 R4 R6
    send_pass(1'b1, 1'b0, 1'b0, -1);
    drain("R1/R2/R3/R4/R6 single pass", 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_small_holes();  // R2 R4 R7 R8
    send_pass(1'b0, 1'b1, 1'b1, -1);
    drain("R7/R4 small pass big drain", 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_multi();        // R5 R11
    send_pass(1'b1, 1'b1, 1'b0, -1);
    send_pass(1'b1, 1'b0, 1'b1, -1);
    send_pass(1'b0, 1'b1, 1'b0, -1);
    drain("R5/R11 overlap stall", 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_small_drain();  // R8
    send_pass(1'b1, 1'b0, 1'b0, -1);
    drain("R8 small drain", 1'b0, 1'b1, 1'b0, 1'b0);
    drain("R8 leftover drain", 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_coincide();     // R9
    send_pass(1'b1, 1'b1, 1'b0, 255);
    drain("R9 coincident request", 1'b1, 1'b0, 1'b0, 1'b0);
    send_pass(1'b0, 1'b0, 1'b0, 20);
    drain("R9 mid-pass request", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_poke();         // R10
    send_pass(1'b0, 1'b1, 1'b0, -1);
    drain("R10 poked drain", 1'b0, 1'b1, 1'b0, 1'b1);
    drain("R10 after poke empty", 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mp[i] = 0; md[i] = 0; mw[i] = 0; end
    t_reset();
    t_single_big();
    t_small_holes();
    t_multi();
    t_small_drain();
    t_coincide();
    t_poke();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule